// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the four addresses of a memory burst from one start address. A load strobe captures the whole start address. Each following advance strobe steps the two low address bits to the next position of the burst. The upper bits stay as captured. A static strap selects the order. When the strap is low, the offset steps up by one modulo four. When the strap is high, the offset is the start offset XOR a running count. After four positions the sequence returns to the start offset.

A clock enable gates every action. While it is low, the sequencer ignores both strobes and keeps its address. The address output is computed combinationally from two registers: the captured base address and a 2-bit count. A new address therefore appears right after the clock edge that loaded or advanced it.

Top module: `burst_seq`

## Requirements
- R1: After reset, curAddr is all zeros.
- R2: After a clock edge with clkEn=1 and loadStb=1, curAddr equals the startAddr that was presented at that edge.
- R3: With modeIlv=0, each enabled advance edge (clkEn=1, loadStb=0, advStb=1) sets curAddr[1:0] to its previous value plus one, modulo 4. From start offsets 0,1,2,3 this gives 0-1-2-3, 1-2-3-0, 2-3-0-1 and 3-0-1-2.
- R4: With modeIlv=1, after k advances since the last load, curAddr[1:0] equals the start offset XOR k. From start offsets 0,1,2,3 this gives 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0.
- R5: The fourth advance after a load returns curAddr to the loaded start address, in either order.
- R6: While clkEn=0, curAddr does not change, whatever loadStb, advStb and startAddr do.
- R7: An advance never changes curAddr[AW-1:2]. Those bits stay as loaded.
- R8: When loadStb and advStb are both 1 on an enabled edge, the load takes effect and the advance is dropped.
- R9: On an enabled edge with loadStb=0 and advStb=0, curAddr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable; when low, the sequencer holds its state |
| loadStb | input | 1 | Capture startAddr and restart the burst |
| advStb | input | 1 | Step to the next burst position |
| modeIlv | input | 1 | Order strap: 0 = linear, 1 = interleaved |
| startAddr | input | AW | Start address of the burst |
| curAddr | output | AW | Current burst address |

## Verification
On every cycle, the bound checker checks these rules: a load is captured (R2), the clock enable freezes the output (R6), a cycle with no strobe holds the output (R9), an advance keeps the upper bits (R7), a linear advance increments the offset (R3), and a load wins over an advance (R8). The full interleaved patterns, the wrap back to the start after four steps, and the reset value appear only in the bench's scenarios. These scenarios run every start offset in both orders and compare each position with a sequence the bench computes itself.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } seqStb_t;

  localparam int OFS_W = 2;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    clkEn,
  input  logic    loadStb,
  input  logic    advStb,
  output seqStb_t stb
);
  // A load takes priority over an advance. The clock enable gates both.
  always_comb begin
    stb.load    = clkEn & loadStb;
    stb.advance = clkEn & ~loadStb & advStb;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seqStb_t       stb,
  input  logic          modeIlv,
  input  logic [AW-1:0] startAddr,
  output logic [AW-1:0] curAddr
);
  localparam int HI_W = AW - OFS_W;

  logic [AW-1:0]    baseAddr;
  logic [OFS_W-1:0] stepCnt;
  logic [OFS_W-1:0] ofsLin;
  logic [OFS_W-1:0] ofsIlv;
  logic [OFS_W-1:0] ofsSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseAddr <= '0;
      stepCnt  <= '0;
    end else if (stb.load) begin
      baseAddr <= startAddr;
      stepCnt  <= '0;
    end else if (stb.advance) begin
      stepCnt  <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    ofsLin = baseAddr[OFS_W-1:0] + stepCnt;
    ofsIlv = baseAddr[OFS_W-1:0] ^ stepCnt;
    ofsSel = modeIlv ? ofsIlv : ofsLin;
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign curAddr = {baseAddr[AW-1:OFS_W], ofsSel};
    end else begin : g_lo
      assign curAddr = ofsSel[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clkEn,
  input  logic          loadStb,
  input  logic          advStb,
  input  logic          modeIlv,
  input  logic [AW-1:0] startAddr,
  output logic [AW-1:0] curAddr
);
  seqStb_t stb;

  burst_seq_ctrl u_ctrl (
    .clkEn   (clkEn),
    .loadStb (loadStb),
    .advStb  (advStb),
    .stb     (stb)
  );

  burst_seq_dp #(.AW(AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .modeIlv   (modeIlv),
    .startAddr (startAddr),
    .curAddr   (curAddr)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clkEn,
  input logic          loadStb,
  input logic          advStb,
  input logic          modeIlv,
  input logic [AW-1:0] startAddr,
  input logic [AW-1:0] curAddr
);
  // R2 and R8
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && loadStb |=> curAddr == $past(startAddr));

  // R6
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clkEn && $stable(modeIlv) |=> $stable(curAddr));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && !loadStb && !advStb && $stable(modeIlv) |=> $stable(curAddr));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && !loadStb && advStb |=> curAddr[AW-1:2] == $past(curAddr[AW-1:2]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn && !loadStb && advStb && !modeIlv |=>
      (!modeIlv -> curAddr[1:0] == 2'($past(curAddr[1:0]) + 2'd1)));
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clkEn     (clkEn),
  .loadStb   (loadStb),
  .advStb    (advStb),
  .modeIlv   (modeIlv),
  .startAddr (startAddr),
  .curAddr   (curAddr)
);

// File: tb/burst_seq_test.sv
module burst_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clkEn = 1'b0;
  logic          loadStb = 1'b0;
  logic          advStb = 1'b0;
  logic          modeIlv = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] curAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .loadStb(loadStb),
    .advStb(advStb), .modeIlv(modeIlv), .startAddr(startAddr), .curAddr(curAddr)
  );

  task automatic check(string req, logic [AW-1:0] exp);
    checks++;
    if (curAddr !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, curAddr, exp);
    end
  endtask

  // One clock edge with the given inputs; the output is sampled 2 ns after the edge.
  task automatic cyc(logic en, logic ld, logic adv, logic [AW-1:0] a);
    clkEn = en; loadStb = ld; advStb = adv; startAddr = a;
    @(posedge clk);
    #2;
    clkEn = 1'b0; loadStb = 1'b0; advStb = 1'b0;
  endtask

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] s, logic ilv, int k);
    logic [1:0] o;
    o = ilv ? (s[1:0] ^ 2'(k)) : 2'(s[1:0] + 2'(k));
    return {s[AW-1:2], o};
  endfunction

  task automatic testReset();
    check("R1", '0);
  endtask

  task automatic testSequence(logic ilv);
    modeIlv = ilv;
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] base;
      base = 20'hA5C30 | AW'(s);
      cyc(1, 1, 0, base);
      check("R2", base);
      for (int k = 1; k <= 4; k++) begin
        cyc(1, 0, 1, 20'h0);
        if (k == 4) check("R5", base);
        else check(ilv ? "R4" : "R3", expAddr(base, ilv, k));
        checks++;
        if (curAddr[AW-1:2] !== base[AW-1:2]) begin
          failures++;
          $display("FAIL R7 actual=%h expected=%h", curAddr[AW-1:2], base[AW-1:2]);
        end
      end
    end
  endtask

  task automatic testEnable();
    logic [AW-1:0] base;
    base = 20'h3F7F2;
    modeIlv = 1'b1;
    cyc(1, 1, 0, base);
    cyc(1, 0, 1, 20'h0);
    cyc(0, 0, 1, 20'h0);
    check("R6", expAddr(base, 1, 1));
    cyc(0, 1, 0, 20'h12345);
    check("R6", expAddr(base, 1, 1));
    cyc(0, 1, 1, 20'hFFFFF);
    check("R6", expAddr(base, 1, 1));
    cyc(1, 0, 1, 20'h0);
    check("R6", expAddr(base, 1, 2));
  endtask

  task automatic testIdle();
    logic [AW-1:0] base;
    base = 20'h00011;
    modeIlv = 1'b0;
    cyc(1, 1, 0, base);
    cyc(1, 0, 1, 20'h0);
    cyc(1, 0, 0, 20'hABCDE);
    check("R9", expAddr(base, 0, 1));
    cyc(1, 0, 0, 20'h55555);
    check("R9", expAddr(base, 0, 1));
  endtask

  task automatic testPriority();
    logic [AW-1:0] base;
    base = 20'h80003;
    modeIlv = 1'b0;
    cyc(1, 1, 0, 20'h00001);
    cyc(1, 0, 1, 20'h0);
    cyc(1, 1, 1, base);
    check("R8", base);
    cyc(1, 0, 1, 20'h0);
    check("R8", expAddr(base, 0, 1));
  endtask

  initial begin
    #35;
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testSequence(1'b0);
    testSequence(1'b1);
    testEnable();
    testIdle();
    testPriority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule